// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block is a synchronous controller that runs write (and simple read) cycles on an external 8K x 8 asynchronous static RAM. A user request carries an address, write data, a write/read flag, a write-style select and an output-enable mode bit. The controller then steps through a fixed phase order: address setup, strobe, hold, recovery. It returns a one-cycle done pulse when it is back at rest.

The memory side has an active-low and an active-high chip select, which always move together. It also has an active-low write enable, an active-low output enable, and a data bus with a separate drive enable. Each phase lasts a number of clock cycles set by a parameter. In the WE-controlled style the selects frame the whole cycle and write enable forms the pulse. In the CS-controlled style write enable falls first and the selects form the pulse, so the memory outputs never turn on. When output enable is held low during a WE-controlled write, the strobe is lengthened to cover the memory's output turn-off time. The data drivers stay off until that time has passed.

Top module: `sram_wr_seq`

## Requirements
- R1: During and after reset, mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and done=0.
- R2: A write with req_cs_style=0 (WE-controlled), accepted at a clock edge, selects the chip from the next cycle through T_AS+L+T_DH+T_WR cycles. Write enable is low only for the L cycles starting T_AS cycles after acceptance.
- R3: A write with req_cs_style=1 (CS-controlled) drives write enable low from the cycle after acceptance through the hold phase. The selects are active only during the L strobe cycles, so they never become active before write enable falls.
- R4: The strobe length L is max(T_WP, T_WHZ+T_DW) for a WE-controlled write with req_oe_low=1. It is max(T_WP, T_DW) for any other write, and T_WP for a read.
- R5: The data drive enable is high from strobe cycle T_WHZ (WE-controlled write with req_oe_low=1) or from strobe cycle 0 (any other write) through the T_DH hold cycles. The data drive enable is never high while mem_oe_n is low.
- R6: During a write with req_oe_low=1, mem_oe_n is low in every busy cycle in which the data bus is not driven. With req_oe_low=0 it stays high throughout the write.
- R7: mem_addr and mem_dq_out take the request's address and data at acceptance. The address changes only in a cycle following one in which write enable or a chip select was inactive.
- R8: done is high for exactly one cycle, T_AS+L+T_DH+T_WR cycles after acceptance. A request presented while busy has no effect on address, strobes or done, and a request held high in the done cycle is accepted at once.
- R9: A read (req_write=0) keeps mem_we_n high and the data drive enable low. It holds the selects active and mem_oe_n low for all busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only at rest |
| req_write | input | 1 | 1 = write, 0 = read |
| req_oe_low | input | 1 | 1 = hold output enable low during the write |
| req_cs_style | input | 1 | 0 = WE-controlled, 1 = CS-controlled |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
A wrong phase or a miscounted phase timer shows up at the strobe pins in the very cycle the phase is entered. A strobe edge one cycle early or late, or a select that is active in the wrong style, is visible on the next sample. A wrong strobe length moves the hold, recovery and done cycles by the same amount, so the done pulse is displaced by that many cycles. A faulty drive-window decode shows at once as the data enable overlapping a low output enable, or as data that is not driven across the end of the write.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STROBE,
    ST_HOLD,
    ST_RECOVER
  } phase_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign last = run && (cnt_q == len - CW'(1));
  assign cnt  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (last)     cnt_d = '0;
    else if (run) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < len)); // R4
endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int CW    = 3,
  parameter int T_AS  = 1,
  parameter int T_WP  = 2,
  parameter int T_WHZ = 1,
  parameter int T_DW  = 1,
  parameter int T_DH  = 1,
  parameter int T_WR  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          lat_write,
  input  logic          lat_oe_low,
  input  logic          lat_cs_style,
  input  logic          last,
  output phase_e        state,
  output logic [CW-1:0] phase_len,
  output logic          accept,
  output logic          run,
  output logic          done
);
  localparam int L_WR_OE = imax(T_WP, T_WHZ + T_DW);
  localparam int L_WR    = imax(T_WP, T_DW);
  localparam int L_RD    = T_WP;

  phase_e state_q, state_d;
  logic   done_q, done_d;

  assign state  = state_q;
  assign run    = (state_q != ST_IDLE);
  assign accept = (state_q == ST_IDLE) && req_valid;
  assign done   = done_q;

  always_comb begin
    phase_len = CW'(1);
    case (state_q)
      ST_ADDR:    phase_len = CW'(T_AS);
      ST_STROBE: begin
        if (!lat_write)                     phase_len = CW'(L_RD);
        else if (lat_oe_low && !lat_cs_style) phase_len = CW'(L_WR_OE);
        else                                phase_len = CW'(L_WR);
      end
      ST_HOLD:    phase_len = CW'(T_DH);
      ST_RECOVER: phase_len = CW'(T_WR);
      default:    phase_len = CW'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_ADDR;
      ST_ADDR:    if (last)      state_d = ST_STROBE;
      ST_STROBE:  if (last)      state_d = ST_HOLD;
      ST_HOLD:    if (last)      state_d = ST_RECOVER;
      ST_RECOVER: if (last)      state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_RECOVER) && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_DONE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(state_q) == ST_RECOVER)); // R8
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int CW    = 3,
  parameter int T_WHZ = 1
) (
  input  phase_e        state,
  input  logic [CW-1:0] cnt,
  input  logic          lat_write,
  input  logic          lat_oe_low,
  input  logic          lat_cs_style,
  output logic          cs_act,
  output logic          we_act,
  output logic          oe_act,
  output logic          drive
);
  logic cs_wr;
  logic busy;

  assign cs_wr = lat_write && lat_cs_style;
  assign busy  = (state != ST_IDLE);

  always_comb begin
    cs_act = 1'b0;
    we_act = 1'b0;
    drive  = 1'b0;
    case (state)
      ST_ADDR: begin
        cs_act = !cs_wr;
        we_act = cs_wr;
      end
      ST_STROBE: begin
        cs_act = 1'b1;
        we_act = lat_write;
        drive  = lat_write && (lat_cs_style || !lat_oe_low || (cnt >= CW'(T_WHZ)));
      end
      ST_HOLD: begin
        cs_act = !cs_wr;
        we_act = cs_wr;
        drive  = lat_write;
      end
      ST_RECOVER: cs_act = !cs_wr;
      default: ;
    endcase
    oe_act = busy && (lat_write ? (lat_oe_low && !drive) : 1'b1);
  end
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int T_AS   = 1,
  parameter int T_WP   = 2,
  parameter int T_WHZ  = 1,
  parameter int T_DW   = 1,
  parameter int T_DH   = 1,
  parameter int T_WR   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_oe_low,
  input  logic              req_cs_style,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  localparam int MAXLEN = imax(imax(imax(T_AS, T_DH), T_WR), imax(T_WP, T_WHZ + T_DW));
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [1:0]        rs_q;
  logic              rst_sn;
  phase_e            state;
  logic [CW-1:0]     phase_len, cnt;
  logic              accept, run, last;
  logic              lat_write, lat_oe_low, lat_cs_style;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic              cs_act, we_act, oe_act, drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      lat_write    <= 1'b0;
      lat_oe_low   <= 1'b0;
      lat_cs_style <= 1'b0;
      lat_addr     <= '0;
      lat_data     <= '0;
    end else if (accept) begin
      lat_write    <= req_write;
      lat_oe_low   <= req_oe_low;
      lat_cs_style <= req_cs_style;
      lat_addr     <= req_addr;
      lat_data     <= req_wdata;
    end
  end

  sram_wr_fsm #(
    .CW(CW), .T_AS(T_AS), .T_WP(T_WP), .T_WHZ(T_WHZ),
    .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)
  ) fsm_i (
    .clk(clk), .rst_n(rst_sn), .req_valid(req_valid),
    .lat_write(lat_write), .lat_oe_low(lat_oe_low), .lat_cs_style(lat_cs_style),
    .last(last), .state(state), .phase_len(phase_len),
    .accept(accept), .run(run), .done(done)
  );

  sram_wr_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_sn), .run(run), .len(phase_len),
    .cnt(cnt), .last(last)
  );

  sram_wr_pins #(.CW(CW), .T_WHZ(T_WHZ)) pins_i (
    .state(state), .cnt(cnt), .lat_write(lat_write),
    .lat_oe_low(lat_oe_low), .lat_cs_style(lat_cs_style),
    .cs_act(cs_act), .we_act(we_act), .oe_act(oe_act), .drive(drive)
  );

  assign mem_addr   = lat_addr;
  assign mem_dq_out = lat_data;
  assign mem_cs1_n  = !cs_act;
  assign mem_cs2    = cs_act;
  assign mem_we_n   = !we_act;
  assign mem_oe_n   = !oe_act;
  assign mem_dq_oe  = drive;

  logic          wr_act;
  logic [CW-1:0] su_q;
  assign wr_act = !mem_we_n && !mem_cs1_n && mem_cs2;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)                  su_q <= '0;
    else if (!wr_act)             su_q <= '0;
    else if (mem_dq_oe && (su_q != {CW{1'b1}})) su_q <= su_q + CW'(1);
  end

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mem_dq_oe && !mem_oe_n)); // R5
  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_addr != $past(mem_addr)) |-> ($past(mem_we_n) || $past(mem_cs1_n) || !$past(mem_cs2))); // R7
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(wr_act) |-> (mem_dq_oe && (su_q >= CW'(T_DW)))); // R5
  AST_CS_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_sn)
    (lat_write && lat_cs_style && $fell(mem_cs1_n)) |-> !mem_we_n); // R3
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sn)
    !lat_write |-> (mem_we_n && !mem_dq_oe)); // R9
  AST_SELECT_PAIR: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_cs2 == !mem_cs1_n); // R2
endmodule

// File: tb/sram_wr_seq_tb_top.sv
module sram_wr_seq_tb_top;
  localparam int AS = 2, WP = 3, WHZ = 2, DW = 2, DH = 2, WR = 1;

  logic        clk, rst_n;
  logic        req_valid, req_write, req_oe_low, req_cs_style;
  logic [12:0] req_addr;
  logic [7:0]  req_wdata;
  logic        done, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq_out;

  int n_chk = 0;
  int n_bad = 0;

  sram_wr_seq #(.T_AS(AS), .T_WP(WP), .T_WHZ(WHZ), .T_DW(DW), .T_DH(DH), .T_WR(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_oe_low(req_oe_low), .req_cs_style(req_cs_style), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
    .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {write, oe_low, cs_style, addr[12:0], data[7:0]}
  localparam logic [23:0] VEC [6] = '{
    {3'b100, 13'h0000, 8'hA5},
    {3'b110, 13'h1FFF, 8'h3C},
    {3'b101, 13'h0ABC, 8'hFF},
    {3'b111, 13'h1234, 8'h00},
    {3'b000, 13'h0F0F, 8'h11},
    {3'b110, 13'h0001, 8'h80}
  };

  function automatic int imx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_rest(input string tag);
    check(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe, tag, "rest pins",
          {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
  endtask

  task automatic run_req(input logic [23:0] v, input bit noise);
    bit w, oe, cs;
    int len, total, d0, we_cnt;
    string stag;
    w = v[23]; oe = v[22]; cs = v[21];
    len = !w ? WP : ((oe && !cs) ? imx(WP, WHZ + DW) : imx(WP, DW));   // R4
    total = AS + len + DH + WR;
    d0 = (w && oe && !cs) ? WHZ : 0;
    stag = !w ? "R9" : (cs ? "R3" : "R2");
    we_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_oe_low = oe; req_cs_style = cs;
    req_addr = v[20:8]; req_wdata = v[7:0];
    for (int i = 0; i <= total + 1; i++) begin
      bit e_cs, e_we, e_dq, e_oe, e_done, strobe, hold;
      @(negedge clk);
      strobe = (i >= AS) && (i < AS + len);
      hold   = (i >= AS + len) && (i < AS + len + DH);
      if (i >= total) begin
        e_cs = 0; e_we = 0; e_dq = 0; e_oe = 0;
      end else if (!w) begin
        e_cs = 1; e_we = 0; e_dq = 0; e_oe = 1;
      end else begin
        e_cs = cs ? strobe : 1'b1;
        e_we = cs ? (i < AS + len + DH) : strobe;
        e_dq = (strobe && (i - AS >= d0)) || hold;
        e_oe = oe && !e_dq;
      end
      e_done = (i == total);
      if (!mem_we_n) we_cnt++;
      check((mem_cs1_n == !e_cs) && (mem_cs2 == e_cs) && (mem_we_n == !e_we), stag,
            $sformatf("strobes cycle %0d", i), {mem_cs1_n, mem_cs2, mem_we_n},
            {!e_cs, e_cs, !e_we});
      check((mem_dq_oe == e_dq) && (!e_dq || mem_dq_out == v[7:0]), "R5",
            $sformatf("data drive cycle %0d", i), {mem_dq_oe, mem_dq_out}, {e_dq, v[7:0]});
      check(mem_oe_n == !e_oe, "R6", $sformatf("oe cycle %0d", i), mem_oe_n, !e_oe);
      check(mem_addr == v[20:8], "R7", $sformatf("addr cycle %0d", i), mem_addr, v[20:8]);
      check(done == e_done, "R8", $sformatf("done cycle %0d", i), done, e_done);
      if (noise && i < total - 1) begin
        req_valid = 1'b1; req_addr = ~v[20:8]; req_wdata = ~v[7:0];
        req_write = ~w; req_cs_style = ~cs;
      end else begin
        req_valid = 1'b0;
      end
    end
    check(we_cnt == (!w ? 0 : (cs ? AS + len + DH : len)), "R4", "write enable low cycles",
          we_cnt, !w ? 0 : (cs ? AS + len + DH : len));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_oe_low = 1'b0;
    req_cs_style = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check_rest("R1");
    check(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_rest("R1");

    foreach (VEC[k]) run_req(VEC[k], (k % 2) == 1);

    // R8: request held high through the done cycle is taken at once
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_oe_low = 1'b0; req_cs_style = 1'b0;
    req_addr = 13'h0055; req_wdata = 8'h5A;
    repeat (AS + imx(WP, DW) + DH + WR + 1) @(negedge clk);
    check(done == 1'b1, "R8", "done while request held", done, 1);
    req_addr = 13'h0066;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_addr == 13'h0066 && !mem_cs1_n && mem_we_n, "R8", "back-to-back accept",
          {mem_addr, mem_cs1_n, mem_we_n}, {13'h0066, 2'b01});

    // R1: reset in mid-strobe returns pins to rest
    repeat (AS + 1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_rest("R1");
    @(negedge clk);
    check(done == 1'b0, "R1", "done after mid-cycle reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_rest("R1");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule